// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Min-Sum Decoder

This block decodes one codeword of a small quasi-cyclic LDPC code. The parity check matrix has two side-by-side groups of square circulants. Each group is the sum of three cyclically shifted identity matrices, and the shift values of both groups together form a disjoint difference set. With the default circulant size of 13 the code has 26 bits and 13 checks. Each bit takes part in three checks and each check covers six bits. The routing between bit nodes and check nodes is worked out at elaboration time from the shift offsets, so no matrix is stored.

A codeword comes in as 26 signed 6-bit channel LLRs. A positive value favours bit 0, and a larger magnitude means more confidence. The decoder runs one message-passing iteration per clock cycle. In each iteration the bit nodes first send bit-to-check messages, then the check nodes send back scaled min-sum messages. Before each iteration the decoder tests the syndrome of the current hard decisions. It stops as soon as that syndrome is zero, or when the iteration limit latched at acceptance is reached. The input is a valid/ready port. `llr_ready` is high only while the decoder is idle, a word is taken on a cycle where `llr_valid` and `llr_ready` are both high, and an offer made while busy simply waits. The result port has no back-pressure: `dec_done` pulses for one cycle, and the result outputs hold their values until the next result.

Top module: `ldpc_qc_decoder`

## Requirements
- R1: After reset `llr_ready` is 1 and `dec_done` is 0.
- R2: While a decode is in progress `llr_ready` is 0, and values offered on `llr_data` during that time do not change the result.
- R3: When `dec_converged` is 1, the syndrome of `dec_bits` is zero. Check row r covers bit g*13+((r+s) mod 13), where s is in {0,1,4} for group g=0 and in {0,2,7} for group g=1.
- R4: If the hard decisions of the channel LLRs already form a codeword, the result has `dec_iters`=0, `dec_converged`=1, and `dec_bits` equal to the channel hard decisions. A bit's hard decision is 1 exactly when its LLR is negative; all +20 decodes to all zeros and all -20 decodes to all ones.
- R5: When `dec_converged` is 0, `dec_iters` equals the iteration limit and the syndrome of `dec_bits` is nonzero. `dec_iters` never exceeds the limit.
- R6: `dec_done` is high for exactly one cycle. It appears in the (`dec_iters`+1)-th cycle after the acceptance edge.
- R7: For an all-zero codeword with every LLR at +20 except one or two bits at a weak negative value (magnitude at most 3), decoding converges after exactly one iteration and `dec_bits` is all zero.
- R8: The iteration limit is sampled at acceptance; changing `iter_limit` during a decode has no effect. Limits of 15, 30 and 50 are supported, and any value up to 63 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llr_valid | input | 1 | Channel word offered |
| llr_ready | output | 1 | Decoder idle and able to accept |
| llr_data | input | 156 | 26 signed 6-bit LLRs, bit j at [6j+5:6j] |
| iter_limit | input | 6 | Maximum number of iterations |
| dec_done | output | 1 | One-cycle result strobe |
| dec_converged | output | 1 | Zero syndrome reached |
| dec_iters | output | 6 | Iterations performed |
| dec_bits | output | 26 | Hard-decision bits |

## Verification
The assertions assume that reset is applied before the first offer. They also assume that `llr_valid` is not raised in the cycle straight after `dec_done` while the output values are still being sampled. The bench keeps to this by dropping `llr_valid` as soon as it sees the done strobe. Random words are zero codewords with bounded noise, so some fail to converge. Those runs check the limit path, and the others check the syndrome and early-exit paths. All limits are kept within 0 to 63.

// File: rtl/ldpc_qc_pkg.sv
package ldpc_qc_pkg;
  localparam int DEF_CIRC = 13;
  localparam int GROUPS   = 2;
  localparam int COLW     = 3;
  localparam int DEF_LLRW = 6;

  // Shift offset t of circulant group g (disjoint difference set)
  function automatic int shift_of(input int g, input int t);
    case (g * COLW + t)
      0: return 0;
      1: return 1;
      2: return 4;
      3: return 0;
      4: return 2;
      5: return 7;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ldpc_check_node.sv
module ldpc_check_node #(
  parameter int LLR_W = 6,
  parameter int DEG   = 6
) (
  input  logic [DEG-1:0][LLR_W-1:0] b2c,
  output logic [DEG-1:0][LLR_W-1:0] c2b
);
  localparam int MW = LLR_W - 1;

  logic [MW-1:0]    mag [DEG];
  logic [DEG-1:0]   sgn;
  logic [MW-1:0]    min1, min2, pick, scaled;
  logic [LLR_W-1:0] neg;
  logic             par;
  int               idx;

  always_comb begin
    min1 = '1;
    min2 = '1;
    idx  = 0;
    par  = 1'b0;
    for (int k = 0; k < DEG; k++) begin
      sgn[k] = b2c[k][MW];
      neg    = -b2c[k];
      mag[k] = sgn[k] ? neg[MW-1:0] : b2c[k][MW-1:0];
      par    = par ^ sgn[k];
      if (mag[k] < min1) begin
        min2 = min1;
        min1 = mag[k];
        idx  = k;
      end else if (mag[k] < min2) begin
        min2 = mag[k];
      end
    end
    for (int k = 0; k < DEG; k++) begin
      pick   = (k == idx) ? min2 : min1;
      scaled = pick - (pick >> 2);
      c2b[k] = (par ^ sgn[k]) ? -{1'b0, scaled} : {1'b0, scaled};
    end
  end
endmodule

// File: rtl/ldpc_bit_node.sv
module ldpc_bit_node #(
  parameter int LLR_W = 6,
  parameter int COLW  = 3
) (
  input  logic signed [LLR_W-1:0]   ch,
  input  logic [COLW-1:0][LLR_W-1:0] c2b,
  output logic [COLW-1:0][LLR_W-1:0] b2c,
  output logic                       hard
);
  localparam int SUM_W = LLR_W + $clog2(COLW + 1);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(2 ** (LLR_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI;

  logic signed [SUM_W-1:0] total, ext;

  always_comb begin
    total = SUM_W'(ch);
    for (int t = 0; t < COLW; t++)
      total = total + SUM_W'($signed(c2b[t]));
    hard = total[SUM_W-1];
    for (int t = 0; t < COLW; t++) begin
      ext = total - SUM_W'($signed(c2b[t]));
      if (ext > HI)      b2c[t] = HI[LLR_W-1:0];
      else if (ext < LO) b2c[t] = LO[LLR_W-1:0];
      else               b2c[t] = ext[LLR_W-1:0];
    end
  end
endmodule

// File: rtl/ldpc_qc_decoder.sv
module ldpc_qc_decoder
  import ldpc_qc_pkg::*;
#(
  parameter int CIRC   = DEF_CIRC,
  parameter int LLR_W  = DEF_LLRW,
  parameter int ITER_W = 6,
  localparam int N     = GROUPS * CIRC,
  localparam int DEG   = GROUPS * COLW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 llr_valid,
  output logic                 llr_ready,
  input  logic [N*LLR_W-1:0]   llr_data,
  input  logic [ITER_W-1:0]    iter_limit,
  output logic                 dec_done,
  output logic                 dec_converged,
  output logic [ITER_W-1:0]    dec_iters,
  output logic [N-1:0]         dec_bits
);
  localparam logic [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};

  logic [N-1:0][LLR_W-1:0]              ch_q;
  logic [CIRC-1:0][DEG-1:0][LLR_W-1:0]  c2b_q, c2b_new, b2c_w;
  logic [N-1:0]                         hard_w;
  logic [CIRC-1:0]                      syn_w;
  logic                                 busy_q;
  logic [ITER_W-1:0]                    iter_q, limit_q;

  // Bit nodes: edge t of bit (g,c) sits in row (c - shift) mod CIRC
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar c = 0; c < CIRC; c++) begin : g_bit
      logic [COLW-1:0][LLR_W-1:0] bn_in, bn_out;
      for (genvar t = 0; t < COLW; t++) begin : g_edge
        localparam int ROW = (c - shift_of(g, t) + CIRC) % CIRC;
        assign bn_in[t] = c2b_q[ROW][g*COLW+t];
        assign b2c_w[ROW][g*COLW+t] = bn_out[t];
      end
      ldpc_bit_node #(.LLR_W(LLR_W), .COLW(COLW)) u_bit (
        .ch   ($signed(ch_q[g*CIRC+c])),
        .c2b  (bn_in),
        .b2c  (bn_out),
        .hard (hard_w[g*CIRC+c])
      );
    end
  end

  for (genvar r = 0; r < CIRC; r++) begin : g_chk
    ldpc_check_node #(.LLR_W(LLR_W), .DEG(DEG)) u_chk (
      .b2c (b2c_w[r]),
      .c2b (c2b_new[r])
    );
  end

  always_comb begin
    syn_w = '0;
    for (int r = 0; r < CIRC; r++)
      for (int g = 0; g < GROUPS; g++)
        for (int t = 0; t < COLW; t++)
          syn_w[r] = syn_w[r] ^ hard_w[g*CIRC + (r + shift_of(g, t)) % CIRC];
  end

  assign llr_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      iter_q        <= '0;
      limit_q       <= '0;
      ch_q          <= '0;
      c2b_q         <= '0;
      dec_done      <= 1'b0;
      dec_converged <= 1'b0;
      dec_iters     <= '0;
      dec_bits      <= '0;
    end else begin
      dec_done <= 1'b0;
      if (!busy_q && llr_valid) begin
        for (int j = 0; j < N; j++) begin
          if (llr_data[j*LLR_W +: LLR_W] == MOST_NEG)
            ch_q[j] <= MOST_NEG + 1'b1;
          else
            ch_q[j] <= llr_data[j*LLR_W +: LLR_W];
        end
        c2b_q   <= '0;
        iter_q  <= '0;
        limit_q <= iter_limit;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (syn_w == '0 || iter_q == limit_q) begin
          busy_q        <= 1'b0;
          dec_done      <= 1'b1;
          dec_converged <= (syn_w == '0);
          dec_iters     <= iter_q;
          dec_bits      <= hard_w;
        end else begin
          c2b_q  <= c2b_new;
          iter_q <= iter_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ldpc_qc_decoder_chk.sv
module ldpc_qc_decoder_chk
  import ldpc_qc_pkg::*;
#(
  parameter int CIRC   = DEF_CIRC,
  parameter int ITER_W = 6,
  localparam int N     = GROUPS * CIRC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              llr_valid,
  input logic              llr_ready,
  input logic [ITER_W-1:0] iter_limit,
  input logic              dec_done,
  input logic              dec_converged,
  input logic [ITER_W-1:0] dec_iters,
  input logic [N-1:0]      dec_bits
);
  logic              accept;
  logic [ITER_W:0]   cnt;
  logic [ITER_W-1:0] lim;
  logic [CIRC-1:0]   syn;

  assign accept = llr_valid && llr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else if (accept) begin
      cnt <= '0;
      lim <= iter_limit;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    syn = '0;
    for (int r = 0; r < CIRC; r++)
      for (int g = 0; g < GROUPS; g++)
        for (int t = 0; t < COLW; t++)
          syn[r] = syn[r] ^ dec_bits[g*CIRC + (r + shift_of(g, t)) % CIRC];
  end

  p_busy_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!llr_ready && !dec_done));

  p_conv_zero_syn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && dec_converged) |-> (syn == '0));

  p_iter_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> (dec_iters <= lim));

  p_limit_reached_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && !dec_converged) |-> (dec_iters == lim && syn != '0));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done);

  p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> (cnt == (ITER_W+1)'({1'b0, dec_iters}) + 1'b1));
endmodule

bind ldpc_qc_decoder ldpc_qc_decoder_chk #(.CIRC(CIRC), .ITER_W(ITER_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .llr_valid     (llr_valid),
  .llr_ready     (llr_ready),
  .iter_limit    (iter_limit),
  .dec_done      (dec_done),
  .dec_converged (dec_converged),
  .dec_iters     (dec_iters),
  .dec_bits      (dec_bits)
);

// File: tb/test_ldpc_qc_decoder.sv
`timescale 1ns/1ps
module test_ldpc_qc_decoder;
  localparam int CIRC = 13;
  localparam int N    = 26;
  localparam int W    = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             llr_valid = 1'b0;
  logic             llr_ready;
  logic [N*W-1:0]   llr_data = '0;
  logic [5:0]       iter_limit = '0;
  logic             dec_done, dec_converged;
  logic [5:0]       dec_iters;
  logic [N-1:0]     dec_bits;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [N*W-1:0] vec;
  int             lat;
  logic           r_conv;
  logic [5:0]     r_iters;
  logic [N-1:0]   r_bits;

  ldpc_qc_decoder i_ldpc_qc_decoder (
    .clk(clk), .rst_n(rst_n), .llr_valid(llr_valid), .llr_ready(llr_ready),
    .llr_data(llr_data), .iter_limit(iter_limit), .dec_done(dec_done),
    .dec_converged(dec_converged), .dec_iters(dec_iters), .dec_bits(dec_bits)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int sh(int g, int t);
    int s;
    s = (g == 0) ? ((t == 0) ? 0 : (t == 1) ? 1 : 4)
                 : ((t == 0) ? 0 : (t == 1) ? 2 : 7);
    return s;
  endfunction

  function automatic logic [CIRC-1:0] syndrome(logic [N-1:0] b);
    logic [CIRC-1:0] s = '0;
    for (int r = 0; r < CIRC; r++)
      for (int g = 0; g < 2; g++)
        for (int t = 0; t < 3; t++)
          s[r] ^= b[g*CIRC + (r + sh(g, t)) % CIRC];
    return s;
  endfunction

  function automatic logic [N-1:0] signs(logic [N*W-1:0] v);
    logic [N-1:0] h;
    for (int j = 0; j < N; j++) h[j] = v[j*W + W - 1];
    return h;
  endfunction

  task automatic check(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic fill(int val);
    for (int j = 0; j < N; j++) vec[j*W +: W] = W'(val);
  endtask

  // Offer vec, optionally keep offering junk while busy, collect the result.
  task automatic run(int lim, bit junk, bit bump_limit);
    @(negedge clk);
    llr_data   = vec;
    iter_limit = 6'(lim);
    llr_valid  = 1'b1;
    @(posedge clk); #1;
    if (junk) begin
      for (int j = 0; j < N; j++) llr_data[j*W +: W] = W'(-20);
    end else begin
      llr_valid = 1'b0;
    end
    if (bump_limit) iter_limit = 6'd50;
    check(llr_ready == 1'b0, "R2", $sformatf("ready while busy actual %0b expected 0", llr_ready));
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!dec_done && lat < 200);
    llr_valid = 1'b0;
    r_conv  = dec_converged;
    r_iters = dec_iters;
    r_bits  = dec_bits;
    check(dec_done && lat == int'(r_iters) + 1, "R6",
          $sformatf("latency actual %0d expected %0d", lat, int'(r_iters) + 1));
    @(posedge clk); #1;
    check(!dec_done, "R6", $sformatf("done width actual %0b expected 0", dec_done));
  endtask

  task automatic generic_checks(int lim);
    if (r_conv)
      check(syndrome(r_bits) == '0, "R3",
            $sformatf("syndrome actual %h expected 0", syndrome(r_bits)));
    else
      check(int'(r_iters) == lim && syndrome(r_bits) != '0, "R5",
            $sformatf("iters actual %0d expected %0d, syndrome %h", r_iters, lim, syndrome(r_bits)));
    if (syndrome(signs(vec)) == '0)
      check(r_conv && r_iters == 0 && r_bits == signs(vec), "R4",
            $sformatf("early exit actual conv %0b iters %0d expected conv 1 iters 0", r_conv, r_iters));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check(llr_ready == 1'b1 && dec_done == 1'b0, "R1",
          $sformatf("reset ready %0b done %0b expected 1 0", llr_ready, dec_done));
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(llr_ready == 1'b1 && dec_done == 1'b0, "R1",
          $sformatf("after reset ready %0b done %0b expected 1 0", llr_ready, dec_done));

    // R4: strong all-zero and all-one codewords
    fill(20); run(15, 0, 0);
    check(r_conv && r_iters == 0 && r_bits == '0, "R4",
          $sformatf("all +20 actual conv %0b iters %0d bits %h expected 1 0 0", r_conv, r_iters, r_bits));
    fill(-20); run(15, 0, 0);
    check(r_conv && r_iters == 0 && r_bits == '1, "R4",
          $sformatf("all -20 actual conv %0b iters %0d bits %h expected 1 0 all ones", r_conv, r_iters, r_bits));

    // R7: weak flips
    fill(20); vec[0*W +: W] = W'(-1); run(30, 0, 0);
    check(r_conv && r_iters == 1 && r_bits == '0, "R7",
          $sformatf("one flip actual conv %0b iters %0d bits %h expected 1 1 0", r_conv, r_iters, r_bits));
    fill(20); vec[5*W +: W] = W'(-3); vec[19*W +: W] = W'(-3); run(50, 0, 0);
    check(r_conv && r_iters == 1 && r_bits == '0, "R7",
          $sformatf("two flips actual conv %0b iters %0d bits %h expected 1 1 0", r_conv, r_iters, r_bits));

    // R2: junk offered while busy must not disturb the result
    fill(20); vec[3*W +: W] = W'(-2); vec[4*W +: W] = W'(-2); run(15, 1, 0);
    check(r_conv && r_iters == 1 && r_bits == '0, "R2",
          $sformatf("junk while busy actual conv %0b iters %0d bits %h expected 1 1 0", r_conv, r_iters, r_bits));

    // R5 / R8: limit zero, raised after acceptance
    fill(20); vec[7*W +: W] = W'(-3); run(0, 0, 1);
    check(!r_conv && r_iters == 0 && r_bits == 26'(1 << 7), "R8",
          $sformatf("limit latch actual conv %0b iters %0d bits %h expected 0 0 %h", r_conv, r_iters, r_bits, 26'(1 << 7)));
    generic_checks(0);

    // Constrained random: zero codeword with bounded noise
    for (int n = 0; n < 60; n++) begin
      int lim;
      int pick;
      pick = int'($urandom % 4);
      lim = (pick == 0) ? 15 : (pick == 1) ? 30 : (pick == 2) ? 50 : int'($urandom % 64);
      for (int j = 0; j < N; j++)
        vec[j*W +: W] = W'(int'($urandom % 19) - 5);
      if (n % 5 == 0) vec[(n % N)*W +: W] = W'(-32);
      run(lim, n % 3 == 0, 0);
      generic_checks(lim);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule